// File: doc/BRIEF.md
# I2C SCL Waveform Generator with SDA Hold Timing

This block produces the serial clock for an I2C master one bit at a time. The master engine raises a bit request. The generator pulls SCL low and counts a programmable low phase. It then releases SCL and counts a programmable high phase. The block gives the engine two timing strobes. The first marks the cycle where SDA may be changed, which is a programmable hold time after the SCL falling edge. The second marks the cycle at the middle of the high phase where SDA should be sampled.

Timing comes from one 32-bit waveform register. The low and high phase lengths are each an 8-bit divider, scaled by a shared power-of-two prescaler, plus a fixed three-cycle offset. The SDA hold count has its own 5-bit field, also plus three cycles. A slave may stretch the clock: the high-phase count starts only once the synchronized SCL line is actually seen high. If a long hold would reach past the end of the low phase, the low phase is lengthened so that the SDA change still falls while SCL is low. The lengths are captured at the start of every bit, so a register write made in the middle of a bit takes effect from the next bit.

Top module: `scl_wave_gen`

## Requirements
- R1: Register bit fields: low divider in bits 7:0, high divider in bits 15:8, prescaler exponent in bits 18:16, clock-source flag in bit 20, hold count in bits 28:24. A write stores all of these bits, and `cfg_rdata` returns them on the next cycle. All other bits read as zero.
- R2: SCL is held low (`scl_out`=0) for exactly LO×2^PRE+3 cycles per bit, provided that value is greater than HOLD+3.
- R3: The high phase counts CH×2^PRE+3 cycles from the first cycle in which the synchronized SCL input is high.
- R4: `sda_chg_stb` pulses exactly once per bit, in the cycle HOLD+3 cycles after the first low cycle (0-based low-cycle index HOLD+3).
- R5: When HOLD+3 is not less than LO×2^PRE+3, the low phase lasts HOLD+4 cycles, so the SDA change strobe always falls while SCL is low.
- R6: While a slave holds the SCL input low after release, the high count does not advance. With no stretching, the released SCL is counted high after the SYNC_STAGES cycles of the input synchronizer.
- R7: `smp_stb` pulses exactly once per bit, at 0-based count index floor((CH×2^PRE+3)/2) of the high phase.
- R8: `bit_ack` pulses in the last high cycle of each bit. If `bit_req` is high in that cycle, SCL goes low on the next cycle with no gap. Otherwise the block goes idle with SCL high and all strobes quiet.
- R9: Phase lengths are captured when a bit starts. A register write made during a bit changes only the following bits.
- R10: The clock-source flag (bit 20) is stored and read back but does not change any timing.
- R11: After reset, `scl_out` is 1, all strobes are 0 and `cfg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the waveform register |
| cfg_wdata | input | 32 | Waveform register write data |
| cfg_rdata | output | 32 | Waveform register read data |
| bit_req | input | 1 | Master engine requests one more SCL bit |
| scl_in | input | 1 | Sensed SCL line level (asynchronous) |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_chg_stb | output | 1 | One-cycle strobe: SDA may change now |
| smp_stb | output | 1 | One-cycle strobe: sample SDA now |
| bit_ack | output | 1 | One-cycle strobe in the last cycle of a bit |

## Verification
Bits are generated under several settings: small dividers with no prescaling, nonzero prescaling with a short hold, the largest prescaler exponent, and a hold longer than the low divider. Each setting separates a correct prescaler shift and offset from a misplaced one, and the long-hold case confirms that the low phase is lengthened rather than cut short. A slave model delays the sensed SCL rise by a chosen number of cycles, which shows whether the high count waits for the line. Back-to-back bits with a write in the middle, and a run with only the clock-source flag changed, check that timing is captured per bit and that the flag has no effect.

// File: rtl/swg_pkg.sv
package swg_pkg;

   // register word and field anchors (software decodes these positions)
   localparam int CFG_W    = 32;
   localparam int LO_POS   = 0;
   localparam int HI_POS   = 8;
   localparam int PRE_POS  = 16;
   localparam int SRC_POS  = 20;
   localparam int HOLD_POS = 24;

   // widest field each anchor leaves room for
   localparam int DIV_ROOM  = 8;
   localparam int PRE_ROOM  = 3;
   localparam int HOLD_ROOM = 5;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   function automatic logic [CFG_W-1:0] field_mask(input int w, input int pos);
      logic [CFG_W-1:0] m;
      m = ((CFG_W'(1) << w) - CFG_W'(1)) << pos;
      return m;
   endfunction

   function automatic logic [CFG_W-1:0] cfg_mask(input int div_w, input int pre_w,
                                                 input int hold_w);
      return field_mask(div_w, LO_POS) | field_mask(div_w, HI_POS) |
             field_mask(pre_w, PRE_POS) | field_mask(1, SRC_POS) |
             field_mask(hold_w, HOLD_POS);
   endfunction

endpackage

// File: rtl/swg_cfg_reg.sv
module swg_cfg_reg #(
   parameter int               W    = 32,
   parameter logic [W-1:0]     MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   logic [W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (wr)
         word_q <= wdata & MASK;
   end

   assign q = word_q;

endmodule

// File: rtl/swg_sync.sv
module swg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i < STAGES; i++)
            chain_q[i] <= chain_q[i-1];
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/swg_len_calc.sv
module swg_len_calc #(
   parameter int DIV_W  = 8,
   parameter int PRE_W  = 3,
   parameter int HOLD_W = 5,
   parameter int OFS    = 3,
   parameter int LEN_W  = 16
) (
   input  logic [DIV_W-1:0]  lo_div,
   input  logic [DIV_W-1:0]  hi_div,
   input  logic [PRE_W-1:0]  pre,
   input  logic [HOLD_W-1:0] hold,
   output logic [LEN_W-1:0]  lo_len,
   output logic [LEN_W-1:0]  hi_len,
   output logic [LEN_W-1:0]  hold_len
);

   localparam int NPRE = 2 ** PRE_W;

   logic [LEN_W-1:0] lo_cand [NPRE];
   logic [LEN_W-1:0] hi_cand [NPRE];
   logic [LEN_W-1:0] lo_raw;

   // one candidate per prescaler exponent; the field picks among them
   for (genvar p = 0; p < NPRE; p++) begin : g_pre
      assign lo_cand[p] = (LEN_W'(lo_div) << p) + LEN_W'(OFS);
      assign hi_cand[p] = (LEN_W'(hi_div) << p) + LEN_W'(OFS);
   end

   assign lo_raw   = lo_cand[pre];
   assign hi_len   = hi_cand[pre];
   assign hold_len = LEN_W'(hold) + LEN_W'(OFS);

   // stretch the low phase so the SDA change lands before SCL rises
   assign lo_len = (lo_raw > hold_len) ? lo_raw : hold_len + LEN_W'(1);

endmodule

// File: rtl/swg_phase_seq.sv
module swg_phase_seq
   import swg_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_req,
   input  logic             scl_seen_hi,
   input  logic [LEN_W-1:0] lo_len,
   input  logic [LEN_W-1:0] hi_len,
   input  logic [LEN_W-1:0] hold_len,
   output logic             scl_out,
   output logic             sda_chg_stb,
   output logic             smp_stb,
   output logic             bit_ack
);

   phase_e           ph_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] lo_q, hi_q, hold_q;
   logic             started_q;
   logic             run_hi;
   logic             lo_end, hi_end, begin_bit;

   assign run_hi    = started_q | scl_seen_hi;
   assign lo_end    = (ph_q == PH_LOW) && (cnt_q == lo_q - LEN_W'(1));
   assign hi_end    = (ph_q == PH_HIGH) && run_hi && (cnt_q == hi_q - LEN_W'(1));
   assign begin_bit = bit_req && ((ph_q == PH_IDLE) || hi_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= PH_IDLE;
         cnt_q     <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
         hold_q    <= '0;
         started_q <= 1'b0;
      end else if (begin_bit) begin
         ph_q   <= PH_LOW;
         cnt_q  <= '0;
         lo_q   <= lo_len;
         hi_q   <= hi_len;
         hold_q <= hold_len;
      end else if (lo_end) begin
         ph_q      <= PH_HIGH;
         cnt_q     <= '0;
         started_q <= 1'b0;
      end else if (hi_end) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else if (ph_q == PH_LOW) begin
         cnt_q <= cnt_q + LEN_W'(1);
      end else if ((ph_q == PH_HIGH) && run_hi) begin
         cnt_q     <= cnt_q + LEN_W'(1);
         started_q <= 1'b1;
      end
   end

   assign scl_out     = (ph_q != PH_LOW);
   assign sda_chg_stb = (ph_q == PH_LOW) && (cnt_q == hold_q);
   assign smp_stb     = (ph_q == PH_HIGH) && run_hi && (cnt_q == (hi_q >> 1));
   assign bit_ack     = hi_end;

endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen
   import swg_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int PRE_W       = 3,
   parameter int HOLD_W      = 5,
   parameter int OFS         = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        bit_req,
   input  logic        scl_in,
   output logic        scl_out,
   output logic        sda_chg_stb,
   output logic        smp_stb,
   output logic        bit_ack
);

   localparam int              NPRE     = 2 ** PRE_W;
   localparam int              MAX_DIV  = ((2 ** DIV_W) - 1) * (2 ** (NPRE - 1)) + OFS;
   localparam int              MAX_HOLD = (2 ** HOLD_W) + OFS;
   localparam int              MAX_LEN  = (MAX_DIV > MAX_HOLD) ? MAX_DIV : MAX_HOLD;
   localparam int              LEN_W    = $clog2(MAX_LEN + 1);
   localparam logic [CFG_W-1:0] CFG_MASK = cfg_mask(DIV_W, PRE_W, HOLD_W);

   // elaboration-time parameter checks
   if (DIV_W < 1 || DIV_W > DIV_ROOM) begin : g_bad_div
      $error("DIV_W must lie in 1..%0d", DIV_ROOM);
   end
   if (PRE_W < 1 || PRE_W > PRE_ROOM) begin : g_bad_pre
      $error("PRE_W must lie in 1..%0d", PRE_ROOM);
   end
   if (HOLD_W < 1 || HOLD_W > HOLD_ROOM) begin : g_bad_hold
      $error("HOLD_W must lie in 1..%0d", HOLD_ROOM);
   end
   if (OFS < 1) begin : g_bad_ofs
      $error("OFS must be at least 1");
   end
   // the shortest low phase must flush the synchronizer of stale highs
   if (SYNC_STAGES < 1 || SYNC_STAGES > OFS + 1) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 1..OFS+1");
   end

   logic [CFG_W-1:0]  cfg_q;
   logic [DIV_W-1:0]  f_lo, f_hi;
   logic [PRE_W-1:0]  f_pre;
   logic [HOLD_W-1:0] f_hold;
   logic [LEN_W-1:0]  lo_len, hi_len, hold_len;
   logic              scl_seen_hi;

   swg_cfg_reg #(
      .W    (CFG_W),
      .MASK (CFG_MASK)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .q     (cfg_q)
   );

   assign cfg_rdata = cfg_q;
   assign f_lo      = cfg_q[LO_POS   +: DIV_W];
   assign f_hi      = cfg_q[HI_POS   +: DIV_W];
   assign f_pre     = cfg_q[PRE_POS  +: PRE_W];
   assign f_hold    = cfg_q[HOLD_POS +: HOLD_W];

   swg_len_calc #(
      .DIV_W  (DIV_W),
      .PRE_W  (PRE_W),
      .HOLD_W (HOLD_W),
      .OFS    (OFS),
      .LEN_W  (LEN_W)
   ) u_len (
      .lo_div   (f_lo),
      .hi_div   (f_hi),
      .pre      (f_pre),
      .hold     (f_hold),
      .lo_len   (lo_len),
      .hi_len   (hi_len),
      .hold_len (hold_len)
   );

   swg_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (scl_seen_hi)
   );

   swg_phase_seq #(
      .LEN_W (LEN_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_req     (bit_req),
      .scl_seen_hi (scl_seen_hi),
      .lo_len      (lo_len),
      .hi_len      (hi_len),
      .hold_len    (hold_len),
      .scl_out     (scl_out),
      .sda_chg_stb (sda_chg_stb),
      .smp_stb     (smp_stb),
      .bit_ack     (bit_ack)
   );

endmodule

// File: rtl/swg_chk.sv
module swg_chk
   import swg_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int PRE_W  = 3,
   parameter int HOLD_W = 5
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_wr,
   input logic [31:0] cfg_wdata,
   input logic [31:0] cfg_rdata,
   input logic        bit_req,
   input logic        scl_out,
   input logic        sda_chg_stb,
   input logic        smp_stb,
   input logic        bit_ack
);

   localparam logic [31:0] MASK = cfg_mask(DIV_W, PRE_W, HOLD_W);

   // remembers whether the SDA change strobe fired in the current low phase
   logic chg_seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chg_seen_q <= 1'b0;
      else if (sda_chg_stb)
         chg_seen_q <= 1'b1;
      else if (scl_out)
         chg_seen_q <= 1'b0;
   end

   AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cfg_rdata == ($past(cfg_wdata) & MASK)));                 // R1
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~MASK) == 32'd0);                                         // R1
   AST_CHG_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      sda_chg_stb |-> !scl_out);                                             // R4
   AST_RISE_AFTER_CHG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_out) |-> chg_seen_q);                                        // R5
   AST_SMP_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> scl_out);                                                  // R7
   AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sda_chg_stb, smp_stb, bit_ack}));                            // R7
   AST_ACK_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_ack && bit_req) |=> !scl_out);                                    // R8
   AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_ack && !bit_req) |=> scl_out);                                    // R8

endmodule

bind scl_wave_gen swg_chk #(
   .DIV_W  (DIV_W),
   .PRE_W  (PRE_W),
   .HOLD_W (HOLD_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr      (cfg_wr),
   .cfg_wdata   (cfg_wdata),
   .cfg_rdata   (cfg_rdata),
   .bit_req     (bit_req),
   .scl_out     (scl_out),
   .sda_chg_stb (sda_chg_stb),
   .smp_stb     (smp_stb),
   .bit_ack     (bit_ack)
);

// File: tb/sim_scl_wave_gen.sv
module sim_scl_wave_gen;

   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic        bit_req;
   logic        scl_in;
   logic        scl_out;
   logic        sda_chg_stb;
   logic        smp_stb;
   logic        bit_ack;

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   // slave model: holds the sensed line low for 'stretch' cycles after release
   int stretch = 0;
   int hi_age  = 0;
   always @(posedge clk) hi_age <= scl_out ? hi_age + 1 : 0;
   assign scl_in = scl_out && (hi_age >= stretch);

   scl_wave_gen u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_wdata   (cfg_wdata),
      .cfg_rdata   (cfg_rdata),
      .bit_req     (bit_req),
      .scl_in      (scl_in),
      .scl_out     (scl_out),
      .sda_chg_stb (sda_chg_stb),
      .smp_stb     (smp_stb),
      .bit_ack     (bit_ack)
   );

   typedef struct {
      int lo;
      int chg;
      int hi;
      int smp;
   } exp_t;

   exp_t sb[$];
   int cur_lo = 0, cur_hi = 0, cur_pre = 0, cur_hold = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic exp_t predict(input int lo, input int hi, input int pre,
                                    input int hold, input int s);
      exp_t e;
      int   l_raw, h_cnt, hl;
      l_raw = (lo << pre) + 3;
      h_cnt = hold + 3;
      hl    = (hi << pre) + 3;
      e.lo  = (l_raw > h_cnt) ? l_raw : h_cnt + 1;
      e.chg = h_cnt;
      e.hi  = s + SYNC + hl;
      e.smp = s + SYNC + hl / 2;
      return e;
   endfunction

   task automatic write_raw(input logic [31:0] w);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_wr    = 1'b0;
   endtask

   task automatic write_cfg(input int lo, input int hi, input int pre, input int hold,
                            input bit src);
      cur_lo = lo; cur_hi = hi; cur_pre = pre; cur_hold = hold;
      write_raw((32'(hold) << 24) | (32'(src) << 20) | (32'(pre) << 16) |
                (32'(hi) << 8) | 32'(lo));
   endtask

   // driver: queue the expectation of each bit, then request that many bits
   task automatic run_bits(input int n, input int s);
      int got;
      stretch = s;
      for (int i = 0; i < n; i++) sb.push_back(predict(cur_lo, cur_hi, cur_pre, cur_hold, s));
      @(negedge clk);
      bit_req = 1'b1;
      got = 0;
      while (got < n) begin
         @(negedge clk);
         if (bit_ack) begin
            got++;
            if (got == n) bit_req = 1'b0;
         end
      end
   endtask

   task automatic check_idle(input string tag);
      repeat (4) @(negedge clk);
      chk(scl_out == 1'b1, tag, int'(scl_out), 1);
      chk({sda_chg_stb, smp_stb, bit_ack} == 3'b000, tag,
          int'({sda_chg_stb, smp_stb, bit_ack}), 0);
   endtask

   // monitor: measure each bit and compare against the queued expectation
   bit   prev_scl = 1'b1;
   bit   in_bit   = 1'b0;
   int   lo_cnt, chg_idx, chg_n, hi_cnt, smp_idx, smp_n;
   exp_t got_e;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!scl_out) begin
            if (prev_scl) begin
               in_bit = 1'b1; lo_cnt = 0; chg_n = 0; smp_n = 0;
               hi_cnt = 0; chg_idx = -1; smp_idx = -1;
            end
            if (sda_chg_stb) begin chg_idx = lo_cnt; chg_n++; end
            lo_cnt++;
         end else if (in_bit) begin
            if (smp_stb) begin smp_idx = hi_cnt; smp_n++; end
            hi_cnt++;
            if (bit_ack) begin
               in_bit = 1'b0;
               if (sb.size() == 0) begin
                  chk(1'b0, "R8 ack with nothing expected", 1, 0);
               end else begin
                  got_e = sb.pop_front();
                  chk(lo_cnt == got_e.lo, "R2/R5 low length", lo_cnt, got_e.lo);
                  chk(chg_idx == got_e.chg, "R4 hold position", chg_idx, got_e.chg);
                  chk(chg_n == 1, "R4 change strobe count", chg_n, 1);
                  chk(hi_cnt == got_e.hi, "R3/R6 high length", hi_cnt, got_e.hi);
                  chk(smp_idx == got_e.smp, "R7 sample position", smp_idx, got_e.smp);
                  chk(smp_n == 1, "R7 sample strobe count", smp_n, 1);
               end
            end
         end else if (sda_chg_stb || smp_stb || bit_ack) begin
            chk(1'b0, "R8 strobe while idle", 1, 0);
         end
         prev_scl = scl_out;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R8 watchdog expired actual %0d expected %0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      cfg_wr    = 1'b0;
      cfg_wdata = '0;
      bit_req   = 1'b0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(scl_out == 1'b1, "R11 scl after reset", int'(scl_out), 1);
      chk({sda_chg_stb, smp_stb, bit_ack} == 3'b000, "R11 strobes after reset",
          int'({sda_chg_stb, smp_stb, bit_ack}), 0);
      chk(cfg_rdata == 32'd0, "R11 register after reset", int'(cfg_rdata), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 field mask and readback
      write_raw(32'hFFFF_FFFF);
      chk(cfg_rdata == 32'h1F17_FFFF, "R1 readback all ones", int'(cfg_rdata), 32'h1F17_FFFF);
      write_raw(32'h00A5_5A00);
      chk(cfg_rdata == 32'h0005_5A00, "R1 readback pattern", int'(cfg_rdata), 32'h0005_5A00);

      // R2 R3 R7 R8: plain dividers, two bits back to back
      write_cfg(4, 5, 0, 0, 1'b0);
      run_bits(2, 0);
      check_idle("R8 idle after bits");

      // R2 R4: prescaler 2 with short hold
      write_cfg(3, 2, 2, 1, 1'b0);
      run_bits(1, 0);

      // R10: same timing with the clock-source flag set
      write_cfg(3, 2, 2, 1, 1'b1);
      chk(cfg_rdata[20] == 1'b1, "R10 source flag stored", int'(cfg_rdata[20]), 1);
      run_bits(1, 0);

      // R5: hold longer than the low divider
      write_cfg(1, 1, 0, 10, 1'b0);
      run_bits(2, 0);

      // R6: slave stretching
      write_cfg(2, 3, 1, 0, 1'b0);
      run_bits(1, 5);
      run_bits(1, 17);

      // R2 R3: largest prescaler exponent
      write_cfg(1, 1, 7, 31, 1'b0);
      run_bits(1, 0);

      // R9: write during the first of two bits affects the second only
      write_cfg(6, 4, 1, 2, 1'b0);
      stretch = 0;
      sb.push_back(predict(6, 4, 1, 2, 0));
      sb.push_back(predict(2, 7, 0, 5, 0));
      @(negedge clk);
      bit_req = 1'b1;
      while (scl_out) @(negedge clk);
      write_cfg(2, 7, 0, 5, 1'b0);
      begin
         int got;
         got = 0;
         while (got < 2) begin
            @(negedge clk);
            if (bit_ack) begin
               got++;
               if (got == 2) bit_req = 1'b0;
            end
         end
      end
      check_idle("R9 idle after chained bits");

      chk(sb.size() == 0, "R8 all bits acknowledged", sb.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule